// File: doc/BRIEF.md
# Parallel Port Peripheral Register Interface

This block is the peripheral side of an enhanced parallel port link. The host side offers only an 8-bit bidirectional data bus plus handshake strobes, with no address lines. Each register access is therefore done in two steps. An address cycle first stores a register number in an internal latch. Then one or more data cycles read or write the register that the latch selects. The latch keeps its value, so repeated data cycles to the same register need no new address cycle.

Behind the interface sit six registers:

- the two bytes of an ADC result (read only);
- an ADC control and status location: writing it hands a control byte to the conversion sequencer and starts a conversion, and reading it returns the end-of-conversion flag;
- a digital I/O location, which drives two output bits and returns two input bits;
- an 8-bit PWM duty value;
- a two-bit PWM enable.

The conversion sequencer and the PWM generators are separate blocks that use these outputs.

The strobes are asynchronous to the system clock. Each passes through a two-flop synchroniser. Registers update one clock after the synchronised strobe edge is detected. The wait line is raised to acknowledge an active strobe and lowered once the strobe is released. The block drives the data bus only during host read cycles.

Top module: `epp_regfile`

## Requirements
- R1: A synchronous active-low reset clears the address latch, the digital outputs, the PWM duty, the PWM enables and the ADC control byte, and leaves the wait output low.
- R2: An address write cycle (address strobe low, write line low) stores data bits 2:0 as the register address. Upper data bits are ignored. An address read cycle returns the stored address in bits 2:0, with bits 7:3 zero.
- R3: A data write while the address is 4 loads all 8 data bits into the PWM duty output.
- R4: A data write while the address is 3 copies data bits 1:0 to the digital outputs. A data read at address 3 returns the digital inputs in bits 1:0, with bits 7:2 zero.
- R5: A data write while the address is 5 copies data bits 1:0 to the two PWM enable outputs.
- R6: A data write while the address is 2 places the byte on the ADC control output and pulses the start output for exactly one clock. A data read at address 2 returns the end-of-conversion flag in bit 0, with bits 7:1 zero.
- R7: A data read at address 0 returns the ADC low byte. A data read at address 1 returns the ADC high byte.
- R8: Addresses 6 and 7 read as 0x00. A write to either changes no output and produces no start pulse.
- R9: The block drives the data bus only while a strobe is low and the write line is high. In all other cases, including host write cycles and idle time, the bus is released.
- R10: The address latch keeps its value across any number of data cycles. Consecutive data cycles without a new address cycle all reach the same register.
- R11: The wait output rises on the third clock edge after a strobe falls (two synchroniser stages plus one register). It falls on the third clock edge after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hst_data | inout | 8 | Bidirectional host data bus |
| hst_nwrite | input | 1 | Host direction: low = host writes, high = host reads |
| hst_ndstb | input | 1 | Data cycle strobe, active low |
| hst_nastb | input | 1 | Address cycle strobe, active low |
| hst_nwait | output | 1 | Handshake acknowledge, high while a strobe is being served |
| adc_lo_i | input | 8 | ADC result low byte |
| adc_hi_i | input | 8 | ADC result high byte |
| adc_done_i | input | 1 | End-of-conversion flag from the sequencer |
| adc_ctrl_o | output | 8 | Last control byte written to the ADC location |
| adc_start_o | output | 1 | One-clock conversion start pulse |
| dig_in_i | input | 2 | Digital input bits |
| dig_out_o | output | 2 | Digital output bits |
| pwm_duty_o | output | 8 | Shared PWM duty value |
| pwm_en_o | output | 2 | PWM channel enables |

## Verification
Address cycles are tried with values that have upper bits set, to show that only bits 2:0 are latched. Each register is then written with complementary patterns (0xFF, 0x00, mixed) so that a stuck bit or a swapped decode shows up, and a repeated data cycle with no new address shows that the latch is kept. Reads at every address are checked against distinct input values, to tell a wrong mux leg from a correct one. Writes to the unused addresses are followed by checks on every output. The handshake is timed clock by clock against the synchroniser depth, and the bus is probed with a host pattern while idle and during writes to show that it is released.

// File: rtl/epp_pkg.sv
// Package: shared widths and register numbers for the parallel port
// register interface. Assumes an 8-bit host bus and a 3-bit address latch.
package epp_pkg;
    localparam int EPP_DATA_W = 8;
    localparam int EPP_ADDR_W = 3;

    typedef logic [EPP_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t REG_ADC_LO  = 3'd0;
    localparam reg_addr_t REG_ADC_HI  = 3'd1;
    localparam reg_addr_t REG_ADC_CTL = 3'd2;
    localparam reg_addr_t REG_DIGIO   = 3'd3;
    localparam reg_addr_t REG_DUTY    = 3'd4;
    localparam reg_addr_t REG_PWM_EN  = 3'd5;
endpackage

// File: rtl/epp_sync.sv
// Module: multi-stage flip-flop synchroniser for asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module epp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_handshake.sv
// Module: strobe synchronisation, falling-edge detection and wait
// generation. Assumes active-low strobes that the host holds until it sees
// the wait line high.
module epp_handshake #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nds_i,
    input  logic nas_i,
    output logic ds_edge_o,
    output logic as_edge_o,
    output logic nwait_o
);
    logic [1:0] strb_s;
    logic       ds_prev, as_prev;

    epp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nds_i, nas_i}),
        .q     (strb_s)
    );

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_prev <= 1'b1;
            as_prev <= 1'b1;
        end else begin
            ds_prev <= strb_s[1];
            as_prev <= strb_s[0];
        end
    end

    assign ds_edge_o = ds_prev & ~strb_s[1];
    assign as_edge_o = as_prev & ~strb_s[0];

    // Acknowledge while either synchronised strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) nwait_o <= 1'b0;
        else        nwait_o <= ~(strb_s[1] & strb_s[0]);
    end

    assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ds_edge_o |=> !ds_edge_o);
    assert_wait_follows_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nwait_o) |-> ($past(!strb_s[1]) || $past(!strb_s[0])));
endmodule

// File: rtl/epp_regbank.sv
// Module: address latch, register storage and read multiplexer.
// Assumes the data bus and the write line are stable while a strobe is
// active, so they can be sampled on the synchronised strobe edge.
module epp_regbank
    import epp_pkg::*;
#(
    parameter int DIO_W  = 2,
    parameter int PWM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ds_edge_i,
    input  logic                  as_edge_i,
    input  logic                  nwrite_i,
    input  logic                  addr_sel_i,
    input  logic [EPP_DATA_W-1:0] din_i,
    output logic [EPP_DATA_W-1:0] rdata_o,
    input  logic [EPP_DATA_W-1:0] adc_lo_i,
    input  logic [EPP_DATA_W-1:0] adc_hi_i,
    input  logic                  adc_done_i,
    input  logic [DIO_W-1:0]      dig_in_i,
    output logic [EPP_DATA_W-1:0] adc_ctrl_o,
    output logic                  adc_start_o,
    output logic [DIO_W-1:0]      dig_out_o,
    output logic [EPP_DATA_W-1:0] pwm_duty_o,
    output logic [PWM_CH-1:0]     pwm_en_o
);
    reg_addr_t addr_q;
    logic      wr_data, wr_addr;

    assign wr_data = ds_edge_i & ~nwrite_i;
    assign wr_addr = as_edge_i & ~nwrite_i;

    // Latch the address and update the addressed register on a write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            adc_ctrl_o  <= '0;
            adc_start_o <= 1'b0;
            dig_out_o   <= '0;
            pwm_duty_o  <= '0;
            pwm_en_o    <= '0;
        end else begin
            adc_start_o <= 1'b0;
            if (wr_addr) addr_q <= din_i[EPP_ADDR_W-1:0];
            if (wr_data) begin
                case (addr_q)
                    REG_ADC_CTL: begin
                        adc_ctrl_o  <= din_i;
                        adc_start_o <= 1'b1;
                    end
                    REG_DIGIO:  dig_out_o  <= din_i[DIO_W-1:0];
                    REG_DUTY:   pwm_duty_o <= din_i;
                    REG_PWM_EN: pwm_en_o   <= din_i[PWM_CH-1:0];
                    default:    ;
                endcase
            end
        end
    end

    // Select the read value for the current cycle type and address.
    always_comb begin
        rdata_o = '0;
        if (addr_sel_i) begin
            rdata_o[EPP_ADDR_W-1:0] = addr_q;
        end else begin
            case (addr_q)
                REG_ADC_LO:  rdata_o = adc_lo_i;
                REG_ADC_HI:  rdata_o = adc_hi_i;
                REG_ADC_CTL: rdata_o[0] = adc_done_i;
                REG_DIGIO:   rdata_o[DIO_W-1:0] = dig_in_i;
                default:     rdata_o = '0;
            endcase
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (addr_q == '0 && dig_out_o == '0 && pwm_duty_o == '0 && pwm_en_o == '0));
    assert_duty_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && addr_q == REG_DUTY) |=> (pwm_duty_o == $past(din_i)));
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);
    assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && addr_q > REG_PWM_EN) |=>
        ($stable(dig_out_o) && $stable(pwm_duty_o) && $stable(pwm_en_o) && !adc_start_o));
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr |=> $stable(addr_q));
endmodule

// File: rtl/epp_regfile.sv
// Module: top of the parallel port register interface. Joins the strobe
// handshake to the register bank and drives the bidirectional bus.
// Assumes the host changes direction only while both strobes are high.
module epp_regfile
    import epp_pkg::*;
#(
    parameter int DIO_W       = 2,
    parameter int PWM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    inout  wire  [EPP_DATA_W-1:0] hst_data,
    input  logic                  hst_nwrite,
    input  logic                  hst_ndstb,
    input  logic                  hst_nastb,
    output logic                  hst_nwait,
    input  logic [EPP_DATA_W-1:0] adc_lo_i,
    input  logic [EPP_DATA_W-1:0] adc_hi_i,
    input  logic                  adc_done_i,
    output logic [EPP_DATA_W-1:0] adc_ctrl_o,
    output logic                  adc_start_o,
    input  logic [DIO_W-1:0]      dig_in_i,
    output logic [DIO_W-1:0]      dig_out_o,
    output logic [EPP_DATA_W-1:0] pwm_duty_o,
    output logic [PWM_CH-1:0]     pwm_en_o
);
    logic                  ds_edge, as_edge;
    logic                  bus_drive;
    logic [EPP_DATA_W-1:0] rdata;

    epp_handshake #(.SYNC_STAGES(SYNC_STAGES)) i_handshake (
        .clk       (clk),
        .rst_n     (rst_n),
        .nds_i     (hst_ndstb),
        .nas_i     (hst_nastb),
        .ds_edge_o (ds_edge),
        .as_edge_o (as_edge),
        .nwait_o   (hst_nwait)
    );

    epp_regbank #(.DIO_W(DIO_W), .PWM_CH(PWM_CH)) i_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .ds_edge_i   (ds_edge),
        .as_edge_i   (as_edge),
        .nwrite_i    (hst_nwrite),
        .addr_sel_i  (~hst_nastb),
        .din_i       (hst_data),
        .rdata_o     (rdata),
        .adc_lo_i    (adc_lo_i),
        .adc_hi_i    (adc_hi_i),
        .adc_done_i  (adc_done_i),
        .dig_in_i    (dig_in_i),
        .adc_ctrl_o  (adc_ctrl_o),
        .adc_start_o (adc_start_o),
        .dig_out_o   (dig_out_o),
        .pwm_duty_o  (pwm_duty_o),
        .pwm_en_o    (pwm_en_o)
    );

    // Drive the bus only during a host read with a strobe active (R9).
    assign bus_drive = hst_nwrite & ~(hst_ndstb & hst_nastb);
    assign hst_data  = bus_drive ? rdata : {EPP_DATA_W{1'bz}};

    assert_wait_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hst_ndstb, 3) && $past(hst_nastb, 3) && $past(hst_ndstb, 2) && $past(hst_nastb, 2))
        |-> !hst_nwait);
endmodule

// File: tb/test_epp_regfile.sv
// Directed bench for epp_regfile: one task per scenario.
module test_epp_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nwrite = 1'b1, ndstb = 1'b1, nastb = 1'b1;
    logic       host_drv = 1'b0;
    logic [7:0] host_val = 8'h00;
    tri   [7:0] hst_data;
    logic       nwait;
    logic [7:0] adc_lo = 8'h00, adc_hi = 8'h00, adc_ctrl, duty;
    logic       adc_done = 1'b0, adc_start;
    logic [1:0] dig_in = 2'b00, dig_out, pwm_en;
    int         checks = 0, errors = 0, starts = 0;

    assign hst_data = host_drv ? host_val : 8'hzz;

    always #10 clk = ~clk;

    epp_regfile i_epp_regfile (
        .clk(clk), .rst_n(rst_n), .hst_data(hst_data), .hst_nwrite(nwrite),
        .hst_ndstb(ndstb), .hst_nastb(nastb), .hst_nwait(nwait),
        .adc_lo_i(adc_lo), .adc_hi_i(adc_hi), .adc_done_i(adc_done),
        .adc_ctrl_o(adc_ctrl), .adc_start_o(adc_start), .dig_in_i(dig_in),
        .dig_out_o(dig_out), .pwm_duty_o(duty), .pwm_en_o(pwm_en)
    );

    always @(posedge clk) if (adc_start) starts <= starts + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_nwait(input logic lvl);
        for (int i = 0; i < 20 && nwait !== lvl; i++) @(negedge clk);
    endtask

    // One host cycle: is_addr picks the strobe, is_wr the direction.
    task automatic host_cycle(input bit is_addr, input bit is_wr,
                              input logic [7:0] wval, output logic [7:0] rval);
        @(negedge clk);
        nwrite   = ~is_wr;
        host_drv = is_wr;
        host_val = wval;
        @(negedge clk);
        if (is_addr) nastb = 1'b0; else ndstb = 1'b0;
        @(negedge clk);
        wait_nwait(1'b1);
        rval = hst_data;
        @(negedge clk);
        nastb = 1'b1;
        ndstb = 1'b1;
        wait_nwait(1'b0);
        @(negedge clk);
        host_drv = 1'b0;
        nwrite   = 1'b1;
    endtask

    task automatic wr_addr(input logic [7:0] a);
        logic [7:0] d;
        host_cycle(1'b1, 1'b1, a, d);
    endtask
    task automatic wr_data(input logic [7:0] v);
        logic [7:0] d;
        host_cycle(1'b0, 1'b1, v, d);
    endtask
    task automatic rd_data(output logic [7:0] v);
        host_cycle(1'b0, 1'b0, 8'h00, v);
    endtask
    task automatic rd_addr(output logic [7:0] v);
        host_cycle(1'b1, 1'b0, 8'h00, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 dig_out", dig_out, 2'b00);
        check("R1 duty", duty, 8'h00);
        check("R1 pwm_en", pwm_en, 2'b00);
        check("R1 adc_ctrl", adc_ctrl, 8'h00);
        check("R1 nwait", nwait, 1'b0);
        rd_addr(v);
        check("R1 addr latch", v, 8'h00);
    endtask

    task automatic t_address;
        logic [7:0] v;
        wr_addr(8'h05);
        rd_addr(v);
        check("R2 addr 5", v, 8'h05);
        wr_addr(8'hFA);
        rd_addr(v);
        check("R2 upper bits ignored", v, 8'h02);
    endtask

    task automatic t_duty;
        wr_addr(8'h04);
        wr_data(8'h3C);
        check("R3 duty 3C", duty, 8'h3C);
        wr_data(8'hFF);
        check("R10 repeat cycle duty FF", duty, 8'hFF);
        wr_data(8'h00);
        check("R10 repeat cycle duty 00", duty, 8'h00);
    endtask

    task automatic t_digio;
        logic [7:0] v;
        wr_addr(8'h03);
        wr_data(8'hFE);
        check("R4 dig_out", dig_out, 2'b10);
        wr_data(8'h01);
        check("R4 dig_out 01", dig_out, 2'b01);
        dig_in = 2'b01;
        rd_data(v);
        check("R4 dig_in 01", v, 8'h01);
        dig_in = 2'b11;
        rd_data(v);
        check("R4 dig_in 11", v, 8'h03);
    endtask

    task automatic t_pwm_en;
        wr_addr(8'h05);
        wr_data(8'h01);
        check("R5 enable 01", pwm_en, 2'b01);
        wr_data(8'hF2);
        check("R5 enable 10", pwm_en, 2'b10);
    endtask

    task automatic t_adc;
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr_addr(8'h02);
        wr_data(8'h5B);
        check("R6 ctrl byte", adc_ctrl, 8'h5B);
        check("R6 one start pulse", starts - s0, 1);
        adc_done = 1'b0;
        rd_data(v);
        check("R6 status busy", v, 8'h00);
        adc_done = 1'b1;
        rd_data(v);
        check("R6 status done", v, 8'h01);
        check("R6 no pulse on read", starts - s0, 1);
        adc_lo = 8'h9A;
        adc_hi = 8'h0C;
        wr_addr(8'h00);
        rd_data(v);
        check("R7 low byte", v, 8'h9A);
        wr_addr(8'h01);
        rd_data(v);
        check("R7 high byte", v, 8'h0C);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        int s0;
        s0 = starts;
        for (int a = 6; a < 8; a++) begin
            wr_addr(8'(a));
            wr_data(8'hFF);
            check("R8 duty unchanged", duty, 8'h00);
            check("R8 dig_out unchanged", dig_out, 2'b01);
            check("R8 pwm_en unchanged", pwm_en, 2'b10);
            check("R8 ctrl unchanged", adc_ctrl, 8'h5B);
            check("R8 no start", starts - s0, 0);
            rd_data(v);
            check("R8 reads zero", v, 8'h00);
        end
    endtask

    task automatic t_bus;
        @(negedge clk);
        host_drv = 1'b1;
        host_val = 8'hA5;
        @(negedge clk);
        check("R9 idle bus released", hst_data, 8'hA5);
        nwrite = 1'b0;
        ndstb  = 1'b0;
        @(negedge clk);
        check("R9 write cycle bus released", hst_data, 8'hA5);
        wait_nwait(1'b1);
        ndstb = 1'b1;
        wait_nwait(1'b0);
        @(negedge clk);
        nwrite   = 1'b1;
        host_drv = 1'b0;
    endtask

    task automatic t_handshake;
        int n;
        @(negedge clk);
        nwrite = 1'b1;
        ndstb  = 1'b0;
        n = 0;
        while (nwait !== 1'b1 && n < 10) begin
            @(negedge clk);
            n++;
        end
        check("R11 rise latency", n, 3);
        ndstb = 1'b1;
        n = 0;
        while (nwait !== 1'b0 && n < 10) begin
            @(negedge clk);
            n++;
        end
        check("R11 fall latency", n, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address();
        t_duty();
        t_digio();
        t_pwm_en();
        t_adc();
        t_unused();
        t_bus();
        t_handshake();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule